// File: doc/BRIEF.md
# JTAG Debug Port Data-Register Path

This block sits behind a JTAG TAP controller and implements the data-register side of a debug port. It decodes two instructions. One reaches the debug port's own registers and the other forwards accesses to an access port. Each scan is 35 bits long. The 3 request bits go in first, followed by 32 data bits. During the same scan, a 3-bit acknowledge and the 32-bit result of the previous read come out.

Accesses to the access port are split across scans. A read is launched by one scan, and its data comes back in the data field of a later scan. That later scan is usually a read of the read-buffer register, which returns the stored result without launching anything. When an access port transfer is still in flight at capture time, the acknowledge reads WAIT and the update of that scan is discarded. If overrun detection is armed, the discarded scan also sets a sticky overrun flag.

The control/status register holds the following:
- the sticky overrun flag and the sticky error flag, both write-one-to-clear;
- the overrun-detect enable;
- the debug and system power-up request and acknowledge bits.

A select register holds the access-port number and the register bank that are used for forwarded accesses.

Top module: `dpjt_access_reg`

## Requirements
- R1: After reset the following hold: no access port request is issued, both power-up requests are low, every register reads zero, and the first scan returns acknowledge OK with data 0.
- R2: A scan shifts 35 bits LSB first. The bits shifted in are RnW at bit 0 (1 = read), the register address bits [3:2] at bits [2:1], and the write data at bits [34:3]. The bits shifted out are the acknowledge at bits [2:0] and the previous read result at bits [34:3].
- R3: The captured acknowledge is 3'b010 (OK) when no access port transfer is outstanding and 3'b001 (WAIT) when one is. No other code is ever captured.
- R4: The update of an OK scan under the access-port instruction issues a one-cycle request. The request carries write = !RnW, the port number from SELECT[31:24], the bank from SELECT[7:4], the address from request bits [2:1] and the scan data. The transfer stays outstanding until a done response arrives.
- R5: Read results appear in the data field of the next OK scan. This covers access port reads (once done), control/status reads (debug address 1) and select reads (debug address 2). A read-buffer read (debug address 3) returns the stored result unchanged and issues no request.
- R6: The update of a scan whose acknowledge was WAIT issues no request and writes no register.
- R7: Control/status bit 0 enables overrun detection. While it is set, a WAIT scan sets sticky overrun at bit 1. While it is clear, bit 1 is left unchanged.
- R8: A done response with the error flag set sets the sticky error flag at control/status bit 5.
- R9: A write of 1 to control/status bit 1 or bit 5 clears that flag, and a write of 0 leaves it as it was. Bit 0 takes the written value.
- R10: Control/status bit 28 drives the debug power-up request and bit 30 drives the system power-up request. Bits 29 and 31 read the debug and system acknowledge inputs, so bits [31:28] all read 1 when both domains are powered.
- R11: SELECT stores bits [31:24] and [7:4], and all its other bits read as zero.
- R12: Debug address 0 reads zero and ignores writes. Capture, shift and update pulses while neither instruction is selected change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (TAP reset) |
| tap_capture | input | 1 | TAP in Capture-DR |
| tap_shift | input | 1 | TAP in Shift-DR |
| tap_update | input | 1 | TAP in Update-DR |
| ir_dp_sel | input | 1 | Debug-port register instruction active |
| ir_ap_sel | input | 1 | Access-port register instruction active |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| dbg_pwr_req | output | 1 | Debug domain power-up request |
| sys_pwr_req | output | 1 | System domain power-up request |
| dbg_pwr_ack | input | 1 | Debug domain powered |
| sys_pwr_ack | input | 1 | System domain powered |
| ap_req_valid | output | 1 | One-cycle access port request |
| ap_req_write | output | 1 | Request is a write |
| ap_req_sel | output | 8 | Access-port number |
| ap_req_bank | output | 4 | Register bank |
| ap_req_addr | output | 2 | Register address bits [3:2] |
| ap_req_wdata | output | 32 | Write data |
| ap_rsp_done | input | 1 | Outstanding transfer completed |
| ap_rsp_err | input | 1 | Completed transfer faulted |
| ap_rsp_rdata | input | 32 | Read data of the completed transfer |

## Verification
The bench builds the block with the package defaults: 32 data bits, an 8-bit port number and a 4-bit bank. Its access port responder can be set to either of two latencies. At 3 cycles a transfer finishes before the next scan, so the OK path and the read-one-scan-late path are exercised. At 40 cycles the next scan arrives while the transfer is still outstanding, which exercises WAIT, the discarded update and the overrun flag with the enable both set and clear.

// File: rtl/dpjt_pkg.sv
package dpjt_pkg;

    localparam int DATA_W = 32;
    localparam int REQ_W  = 3;
    localparam int SCAN_W = REQ_W + DATA_W;
    localparam int SEL_W  = 8;
    localparam int BANK_W = 4;

    // control/status bit positions
    localparam int CS_ORUN_EN   = 0;
    localparam int CS_STK_ORUN  = 1;
    localparam int CS_STK_ERR   = 5;
    localparam int CS_DBG_REQ   = 28;
    localparam int CS_DBG_ACK   = 29;
    localparam int CS_SYS_REQ   = 30;
    localparam int CS_SYS_ACK   = 31;

    // select register field positions
    localparam int SEL_LSB  = DATA_W - SEL_W;
    localparam int BANK_LSB = 4;

    typedef enum logic [REQ_W-1:0] {
        ACK_WAIT = 3'b001,
        ACK_OK   = 3'b010
    } ack_e;

    typedef enum logic [1:0] {
        DP_NONE  = 2'd0,
        DP_CTRL  = 2'd1,
        DP_SEL   = 2'd2,
        DP_RDBUF = 2'd3
    } dp_addr_e;

    // shift register image after 35 shifts: data on top, RnW at bit 0
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [1:0]        addr;
        logic              rnw;
    } scan_req_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [SEL_W-1:0]  sel;
        logic [BANK_W-1:0] bank;
        logic [1:0]        addr;
        logic [DATA_W-1:0] wdata;
    } ap_req_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(
        input logic orun_en, input logic stk_orun, input logic stk_err,
        input logic dreq, input logic dack, input logic sreq, input logic sack);
        logic [DATA_W-1:0] v;
        v              = '0;
        v[CS_ORUN_EN]  = orun_en;
        v[CS_STK_ORUN] = stk_orun;
        v[CS_STK_ERR]  = stk_err;
        v[CS_DBG_REQ]  = dreq;
        v[CS_DBG_ACK]  = dack;
        v[CS_SYS_REQ]  = sreq;
        v[CS_SYS_ACK]  = sack;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_sel(
        input logic [SEL_W-1:0] sel, input logic [BANK_W-1:0] bank);
        logic [DATA_W-1:0] v;
        v                             = '0;
        v[SEL_LSB +: SEL_W]           = sel;
        v[BANK_LSB +: BANK_W]         = bank;
        return v;
    endfunction

endpackage

// File: rtl/dpjt_shift.sv
module dpjt_shift
    import dpjt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              cap,
    input  logic              shift,
    input  logic              upd,
    input  logic              tdi,
    input  ack_e              ack_in,
    input  logic [DATA_W-1:0] cap_data,
    output logic              tdo,
    output scan_req_t         req_out,
    output logic              upd_go,
    output logic              upd_wait
);

    logic [SCAN_W-1:0] sr;
    logic              wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            wait_q <= 1'b0;
        end else if (sel) begin
            if (cap) begin
                sr     <= {cap_data, ack_in};
                wait_q <= (ack_in == ACK_WAIT);
            end else if (shift) begin
                sr <= {tdi, sr[SCAN_W-1:1]};
            end
        end
    end

    assign tdo      = sr[0];
    assign req_out  = scan_req_t'(sr);
    assign upd_go   = sel && upd && !wait_q;
    assign upd_wait = sel && upd && wait_q;

    assert_ack_legal_R3: assert property (@(posedge clk) disable iff (rst)
        (sel && cap) |=> (sr[REQ_W-1:0] == ACK_OK || sr[REQ_W-1:0] == ACK_WAIT))
        else $error("captured acknowledge is not OK or WAIT");

endmodule

// File: rtl/dpjt_regs.sv
module dpjt_regs
    import dpjt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_go,
    input  logic              upd_wait,
    input  logic              is_ap,
    input  scan_req_t         req,
    input  logic              dbg_ack,
    input  logic              sys_ack,
    input  logic              rsp_done,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_rdata,
    output ack_e              ack,
    output logic [DATA_W-1:0] rd_buf,
    output ap_req_t           ap_req,
    output logic              dbg_req,
    output logic              sys_req
);

    logic              pending;
    logic              orun_en, stk_orun, stk_err;
    logic [SEL_W-1:0]  sel_q;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] ctrl_rd;
    dp_addr_e          dp_addr;

    assign ctrl_rd = pack_ctrl(orun_en, stk_orun, stk_err, dbg_req, dbg_ack, sys_req, sys_ack);
    assign dp_addr = dp_addr_e'(req.addr);
    assign ack     = pending ? ACK_WAIT : ACK_OK;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            rd_buf   <= '0;
            ap_req   <= '0;
            orun_en  <= 1'b0;
            stk_orun <= 1'b0;
            stk_err  <= 1'b0;
            dbg_req  <= 1'b0;
            sys_req  <= 1'b0;
            sel_q    <= '0;
            bank_q   <= '0;
        end else begin
            ap_req.valid <= 1'b0;
            if (rsp_done && pending) begin
                pending <= 1'b0;
                if (!ap_req.write) rd_buf <= rsp_rdata;
                if (rsp_err)       stk_err <= 1'b1;
            end
            if (upd_wait && orun_en) stk_orun <= 1'b1;
            if (upd_go) begin
                if (is_ap) begin
                    ap_req  <= '{valid: 1'b1, write: !req.rnw, sel: sel_q, bank: bank_q,
                                 addr: req.addr, wdata: req.data};
                    pending <= 1'b1;
                end else begin
                    unique case (dp_addr)
                        DP_NONE:  if (req.rnw) rd_buf <= '0;
                        DP_CTRL: begin
                            if (req.rnw) rd_buf <= ctrl_rd;
                            else begin
                                orun_en <= req.data[CS_ORUN_EN];
                                dbg_req <= req.data[CS_DBG_REQ];
                                sys_req <= req.data[CS_SYS_REQ];
                                if (req.data[CS_STK_ORUN]) stk_orun <= 1'b0;
                                if (req.data[CS_STK_ERR])  stk_err  <= 1'b0;
                            end
                        end
                        DP_SEL: begin
                            if (req.rnw) rd_buf <= pack_sel(sel_q, bank_q);
                            else begin
                                sel_q  <= req.data[SEL_LSB +: SEL_W];
                                bank_q <= req.data[BANK_LSB +: BANK_W];
                            end
                        end
                        DP_RDBUF: ;
                        default: ;
                    endcase
                end
            end
        end
    end

    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        ap_req.valid |=> !ap_req.valid)
        else $error("access port request longer than one cycle");

    assert_no_req_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (pending && !ap_req.valid) |=> !ap_req.valid)
        else $error("request issued while a transfer is outstanding");

    assert_orun_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stk_orun) |-> $past(orun_en))
        else $error("sticky overrun set with detection disabled");

    assert_err_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stk_err) |-> $past(rsp_done && rsp_err))
        else $error("sticky error set without an error response");

endmodule

// File: rtl/dpjt_access_reg.sv
module dpjt_access_reg
    import dpjt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tap_capture,
    input  logic        tap_shift,
    input  logic        tap_update,
    input  logic        ir_dp_sel,
    input  logic        ir_ap_sel,
    input  logic        tdi,
    output logic        tdo,
    output logic        dbg_pwr_req,
    output logic        sys_pwr_req,
    input  logic        dbg_pwr_ack,
    input  logic        sys_pwr_ack,
    output logic        ap_req_valid,
    output logic        ap_req_write,
    output logic [7:0]  ap_req_sel,
    output logic [3:0]  ap_req_bank,
    output logic [1:0]  ap_req_addr,
    output logic [31:0] ap_req_wdata,
    input  logic        ap_rsp_done,
    input  logic        ap_rsp_err,
    input  logic [31:0] ap_rsp_rdata
);

    logic              any_sel, upd_go, upd_wait;
    ack_e              ack;
    logic [DATA_W-1:0] rd_buf;
    scan_req_t         req;
    ap_req_t           ap_req;

    assign any_sel = ir_dp_sel || ir_ap_sel;

    dpjt_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sel      (any_sel),
        .cap      (tap_capture),
        .shift    (tap_shift),
        .upd      (tap_update),
        .tdi      (tdi),
        .ack_in   (ack),
        .cap_data (rd_buf),
        .tdo      (tdo),
        .req_out  (req),
        .upd_go   (upd_go),
        .upd_wait (upd_wait)
    );

    dpjt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .upd_go    (upd_go),
        .upd_wait  (upd_wait),
        .is_ap     (ir_ap_sel),
        .req       (req),
        .dbg_ack   (dbg_pwr_ack),
        .sys_ack   (sys_pwr_ack),
        .rsp_done  (ap_rsp_done),
        .rsp_err   (ap_rsp_err),
        .rsp_rdata (ap_rsp_rdata),
        .ack       (ack),
        .rd_buf    (rd_buf),
        .ap_req    (ap_req),
        .dbg_req   (dbg_pwr_req),
        .sys_req   (sys_pwr_req)
    );

    assign ap_req_valid = ap_req.valid;
    assign ap_req_write = ap_req.write;
    assign ap_req_sel   = ap_req.sel;
    assign ap_req_bank  = ap_req.bank;
    assign ap_req_addr  = ap_req.addr;
    assign ap_req_wdata = ap_req.wdata;

endmodule

// File: tb/tb_dpjt_access_reg.sv
module tb_dpjt_access_reg;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic tap_capture = 0, tap_shift = 0, tap_update = 0;
    logic ir_dp_sel = 0, ir_ap_sel = 0, tdi = 0, tdo;
    logic dbg_pwr_req, sys_pwr_req, dbg_pwr_ack = 0, sys_pwr_ack = 0;
    logic ap_req_valid, ap_req_write;
    logic [7:0] ap_req_sel;
    logic [3:0] ap_req_bank;
    logic [1:0] ap_req_addr;
    logic [31:0] ap_req_wdata;
    logic ap_rsp_done = 0, ap_rsp_err = 0;
    logic [31:0] ap_rsp_rdata = 0;

    dpjt_access_reg dut (.*);

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    // reference model state
    bit m_busy, m_oen, m_sorun, m_serr, m_dreq, m_sreq;
    logic [31:0] m_rd;
    logic [7:0] m_sel;
    logic [3:0] m_bank;
    bit exp_flag, seen_req, exp_write, r_read, inj_err;
    logic [7:0] exp_sel; logic [3:0] exp_bank; logic [1:0] exp_addr; logic [31:0] exp_wdata;
    logic [31:0] r_data;
    int lat = 3, cnt;

    function automatic logic [31:0] ctrl_val();
        logic [31:0] v = '0;
        v[0] = m_oen; v[1] = m_sorun; v[5] = m_serr;
        v[28] = m_dreq; v[29] = dbg_pwr_ack; v[30] = m_sreq; v[31] = sys_pwr_ack;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // access port responder, acts 1 time unit after each rising edge
    initial forever begin
        @(posedge clk); #1;
        if (ap_rsp_done) begin
            ap_rsp_done = 0; ap_rsp_err = 0; m_busy = 0;
            if (r_read) m_rd = r_data;
            if (inj_err) m_serr = 1;
        end
        if (ap_req_valid) begin
            seen_req = 1;
            check(exp_flag, "R6 unexpected request", 64'(ap_req_valid), 64'(0));
            if (exp_flag)
                check({ap_req_write, ap_req_sel, ap_req_bank, ap_req_addr, ap_req_wdata} ==
                      {exp_write, exp_sel, exp_bank, exp_addr, exp_wdata}, "R4 request fields",
                      {ap_req_write, ap_req_sel, ap_req_bank, ap_req_addr, ap_req_wdata},
                      {exp_write, exp_sel, exp_bank, exp_addr, exp_wdata});
            m_busy = 1; cnt = lat; r_read = !ap_req_write;
            r_data = {ap_req_sel, 8'hC3, 4'h0, ap_req_bank, 6'h0, ap_req_addr};
        end else if (m_busy) begin
            if (cnt > 1) cnt--;
            else begin ap_rsp_done = 1; ap_rsp_err = inj_err; ap_rsp_rdata = r_data; end
        end
    end

    // per-clock comparison of the power-up request outputs (R10)
    initial forever begin
        @(posedge clk); #3;
        if (!rst) check({dbg_pwr_req, sys_pwr_req} == {m_dreq, m_sreq}, "R10 power requests",
                        64'({dbg_pwr_req, sys_pwr_req}), 64'({m_dreq, m_sreq}));
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic scan(input bit ap, input bit sel_on, input bit rnw, input logic [1:0] a,
                        input logic [31:0] d, input string tag);
        logic [34:0] exp_out, got, word;
        bit wait_pred;
        wait_pred = m_busy;
        exp_out = {m_rd, (m_busy ? 3'b001 : 3'b010)};
        word = {d, a, rnw};
        ir_dp_sel = sel_on && !ap; ir_ap_sel = sel_on && ap;
        tap_capture = 1; @(negedge clk); tap_capture = 0; tap_shift = 1;
        for (int i = 0; i < 35; i++) begin
            tdi = word[i]; got[i] = tdo; @(negedge clk);
        end
        tap_shift = 0; tap_update = 1;
        if (sel_on) begin
            if (wait_pred) begin
                if (m_oen) m_sorun = 1;
            end else if (ap) begin
                exp_flag = 1; exp_write = !rnw; exp_sel = m_sel; exp_bank = m_bank;
                exp_addr = a; exp_wdata = d;
            end else begin
                case (a)
                    2'd0: if (rnw) m_rd = 0;
                    2'd1: if (rnw) m_rd = ctrl_val();
                          else begin
                              m_oen = d[0]; m_dreq = d[28]; m_sreq = d[30];
                              if (d[1]) m_sorun = 0;
                              if (d[5]) m_serr = 0;
                          end
                    2'd2: if (rnw) m_rd = {m_sel, 16'h0, m_bank, 4'h0};
                          else begin m_sel = d[31:24]; m_bank = d[7:4]; end
                    default: ;
                endcase
            end
        end
        @(negedge clk); tap_update = 0; ir_dp_sel = 0; ir_ap_sel = 0;
        check(exp_flag == seen_req, {tag, " request issued"}, 64'(seen_req), 64'(exp_flag));
        exp_flag = 0; seen_req = 0;
        if (sel_on) check(got == exp_out, {tag, " scan out"}, 64'(got), 64'(exp_out));
    endtask

    initial begin
        m_rd = 0; m_sel = 0; m_bank = 0;
        idle(3); rst = 0; idle(1);
        check({ap_req_valid, dbg_pwr_req, sys_pwr_req, tdo} == 4'b0, "R1 reset outputs",
              64'({ap_req_valid, dbg_pwr_req, sys_pwr_req, tdo}), 64'(0));
        scan(0, 1, 1, 2'd1, 32'h0, "R1 first scan");
        scan(0, 1, 1, 2'd3, 32'h0, "R1 ctrl zero");
        // SELECT layout and read-buffer behaviour
        scan(0, 1, 0, 2'd2, 32'h5AFF_0FB7, "R11 select write");
        scan(0, 1, 1, 2'd2, 32'h0, "R11 select read");
        scan(0, 1, 1, 2'd3, 32'h0, "R11 select value");
        scan(0, 1, 1, 2'd3, 32'h1234_5678, "R5 read buffer repeat");
        // access port write and read, short latency
        scan(1, 1, 0, 2'd2, 32'hCAFE_F00D, "R4 ap write"); idle(6);
        scan(1, 1, 1, 2'd1, 32'h0, "R4 ap read"); idle(6);
        scan(0, 1, 1, 2'd3, 32'h0, "R5 ap read data");
        scan(0, 1, 1, 2'd3, 32'h0, "R2 scan order");
        // long latency, overrun detection off
        lat = 40;
        scan(1, 1, 1, 2'd0, 32'h0, "R3 ap read busy");
        scan(1, 1, 0, 2'd3, 32'hDEAD_BEEF, "R6 wait scan");
        scan(0, 1, 0, 2'd2, 32'h1100_0020, "R6 wait dp write"); idle(50);
        scan(0, 1, 1, 2'd2, 32'h0, "R6 select kept");
        scan(0, 1, 1, 2'd1, 32'h0, "R3 ok again");
        scan(0, 1, 1, 2'd3, 32'h0, "R7 no overrun when disabled");
        // overrun detection on
        scan(0, 1, 0, 2'd1, 32'h0000_0001, "R7 enable");
        scan(1, 1, 1, 2'd1, 32'h0, "R7 ap read");
        scan(1, 1, 1, 2'd1, 32'h0, "R7 overrun scan"); idle(50);
        scan(0, 1, 0, 2'd1, 32'h0000_0001, "R9 write zero keeps");
        scan(0, 1, 1, 2'd1, 32'h0, "R7 ctrl read");
        scan(0, 1, 0, 2'd1, 32'h0000_0003, "R9 clear overrun");
        scan(0, 1, 1, 2'd1, 32'h0, "R9 ctrl read");
        // sticky error
        lat = 3; inj_err = 1;
        scan(1, 1, 0, 2'd0, 32'h0000_00AA, "R8 faulting write"); idle(6);
        inj_err = 0;
        scan(0, 1, 1, 2'd1, 32'h0, "R8 ctrl read");
        scan(0, 1, 0, 2'd1, 32'h0000_0020, "R9 clear error");
        scan(0, 1, 1, 2'd1, 32'h0, "R9 error cleared");
        // power-up handshake
        scan(0, 1, 0, 2'd1, 32'h5000_0000, "R10 request power");
        dbg_pwr_ack = 1; sys_pwr_ack = 1; idle(2);
        check({dbg_pwr_req, sys_pwr_req} == 2'b11, "R10 request outputs",
              64'({dbg_pwr_req, sys_pwr_req}), 64'(3));
        scan(0, 1, 1, 2'd1, 32'h0, "R10 powered read");
        scan(0, 1, 1, 2'd3, 32'h0, "R10 top nibble");
        dbg_pwr_ack = 0;
        scan(0, 1, 1, 2'd1, 32'h0, "R10 debug ack low");
        // address 0 and unselected scans
        scan(0, 1, 0, 2'd0, 32'hFFFF_FFFF, "R12 address 0 write");
        scan(0, 1, 1, 2'd0, 32'h0, "R12 address 0 read");
        scan(0, 1, 1, 2'd3, 32'h0, "R12 reads zero");
        scan(0, 0, 0, 2'd1, 32'h0000_0023, "R12 unselected");
        scan(0, 0, 0, 2'd2, 32'hFF00_00F0, "R12 unselected select");
        scan(0, 1, 1, 2'd1, 32'h0, "R12 ctrl unchanged");
        scan(0, 1, 1, 2'd2, 32'h0, "R12 select unchanged");
        scan(0, 1, 1, 2'd3, 32'h0, "R12 final");
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule